// File: doc/BRIEF.md
# Integer Resampling Step Generator

This block walks one axis of a resampler. For every output pixel it reports the index of the source pixel to fetch and a 4-bit filter phase that says how far the output sample sits between that source pixel and the next. It uses no fractional step register. An error accumulator is raised by the source size on every output strobe. When the accumulator reaches the destination size, the source index moves forward by one and the destination size is taken off the accumulator. Because the stepping is exact integer arithmetic, the first output pixel of a line always lands on source pixel 0 and the last one lands on the last source pixel.

The caller gives both sizes as last-pixel indices (size minus one). The caller pulses a line-start input at the top of each line and a step input once per output pixel. The residue left in the accumulator is a fraction of the destination size, not a power of two. A small comparator chain converts it into one of 16 phases, so a coefficient table indexed by phase can be used directly. The block is meant for an upscaling axis, where the source size is no larger than the destination size. Once the source index reaches the last source pixel, it stays there.

Top module: `scale_stepper`

## Requirements
- R1: After reset, `src_idx` is 0, `phase` is 0 and `src_adv` is 0.
- R2: A `line_start` pulse clears the source index and the residue, so `src_idx` and `phase` read 0 on the next cycle. It takes priority over a `step` in the same cycle.
- R3: The source size is `src_last`+1 and the destination size is `dst_last`+1.
- R4: After k steps since line start, `src_idx` equals floor(k*Nsrc/Ndst), limited to at most Nsrc-1. Here Nsrc and Ndst are the sizes from R3.
- R5: With 320 source and 1920 destination pixels, `src_idx` rises by exactly one on every sixth step: it reads 1 after 6 steps and 2 after 12 steps.
- R6: When Nsrc <= Ndst, output pixel 0 reads source index 0 and output pixel Ndst-1 (after Ndst-1 steps) reads source index Nsrc-1.
- R7: `phase` equals floor(16*r/Ndst), where r = (k*Nsrc) mod Ndst is the accumulator residue after k steps. It is valid in the same cycle as `src_idx`.
- R8: Once `src_idx` equals Nsrc-1, further steps leave it at Nsrc-1 and never wrap it to 0.
- R9: `src_adv` is high for exactly the one cycle after a step that changed `src_idx`. It is low in every other cycle.
- R10: In a cycle with neither `step` nor `line_start`, `src_idx` and `phase` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_last | input | W | Source size minus one |
| dst_last | input | W | Destination size minus one |
| line_start | input | 1 | Restart the axis at output pixel 0 |
| step | input | 1 | Advance one output pixel |
| src_idx | output | W | Source pixel index for the current output pixel |
| src_adv | output | 1 | Source index moved on the last step |
| phase | output | 4 | Filter phase, in sixteenths of a source pixel |

## Verification
A wrong accumulator value shows up at the ports within one step. The next index boundary comes one output pixel early or late, and the phase no longer matches floor(16*r/Ndst). Every step is therefore compared against a closed-form model of the index and the residue. An index that slips or wraps shows at once against the floor formula and at the end of line, where the last output pixel must read the last source pixel. A stuck or stale advance flag shows in the single cycle after any step.

// File: rtl/scale_pkg.sv
package scale_pkg;
    localparam int PHASE_W = 4;

    typedef logic [PHASE_W-1:0] phase_t;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_CLEAR = 2'd1,
        ACT_STEP  = 2'd2
    } act_e;

    // line restart wins over a step in the same cycle
    function automatic act_e pick_act(input logic restart, input logic adv_px);
        if (restart)
            return ACT_CLEAR;
        else if (adv_px)
            return ACT_STEP;
        else
            return ACT_HOLD;
    endfunction
endpackage

// File: rtl/step_accum.sv
module step_accum
    import scale_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  act_e         act,
    input  logic [W:0]   n_src,
    input  logic [W:0]   n_dst,
    output logic [W-1:0] idx,
    output logic [W:0]   acc,
    output logic         adv
);
    logic [W+1:0] sum;
    logic [W+1:0] nxt;
    logic         wrap;
    logic         at_end;

    assign sum    = {1'b0, acc} + {1'b0, n_src};
    assign wrap   = sum >= {1'b0, n_dst};
    assign nxt    = wrap ? (sum - {1'b0, n_dst}) : sum;
    assign at_end = {1'b0, idx} == (n_src - (W+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
            acc <= '0;
            adv <= 1'b0;
        end else begin
            unique case (act)
                ACT_CLEAR: begin
                    idx <= '0;
                    acc <= '0;
                    adv <= 1'b0;
                end
                ACT_STEP: begin
                    acc <= nxt[W:0];
                    if (wrap && !at_end) begin
                        idx <= idx + W'(1);
                        adv <= 1'b1;
                    end else begin
                        adv <= 1'b0;
                    end
                end
                default: adv <= 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/phase_div.sv
module phase_div
    import scale_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W:0] num,
    input  logic [W:0] den,
    output phase_t     q
);
    // restoring division, one compare per quotient bit; num < den assumed
    logic [W+1:0] rem [0:PHASE_W];

    assign rem[0] = {1'b0, num};

    for (genvar i = 0; i < PHASE_W; i++) begin : g_stage
        logic [W+1:0] dbl;
        logic         ge;
        assign dbl    = {rem[i][W:0], 1'b0};
        assign ge     = dbl >= {1'b0, den};
        assign rem[i+1] = ge ? (dbl - {1'b0, den}) : dbl;
        assign q[PHASE_W-1-i] = ge;
    end
endmodule

// File: rtl/scale_stepper.sv
module scale_stepper
    import scale_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] src_last,
    input  logic [W-1:0] dst_last,
    input  logic         line_start,
    input  logic         step,
    output logic [W-1:0] src_idx,
    output logic         src_adv,
    output logic [3:0]   phase
);
    logic [W:0] n_src;
    logic [W:0] n_dst;
    logic [W:0] acc_q;
    act_e       act;
    phase_t     ph;

    assign n_src = {1'b0, src_last} + (W+1)'(1);
    assign n_dst = {1'b0, dst_last} + (W+1)'(1);
    assign act   = pick_act(line_start, step);

    step_accum #(.W(W)) u_accum (
        .clk  (clk),
        .rst  (rst),
        .act  (act),
        .n_src(n_src),
        .n_dst(n_dst),
        .idx  (src_idx),
        .acc  (acc_q),
        .adv  (src_adv)
    );

    phase_div #(.W(W)) u_phase (
        .num(acc_q),
        .den(n_dst),
        .q  (ph)
    );

    assign phase = ph;
endmodule

// File: rtl/scale_stepper_chk.sv
module scale_stepper_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] src_last,
    input logic [W-1:0] dst_last,
    input logic         line_start,
    input logic         step,
    input logic [W-1:0] src_idx,
    input logic         src_adv,
    input logic [3:0]   phase,
    input logic [W:0]   acc
);
    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        line_start |=> (src_idx == '0) && (phase == 4'd0) && !src_adv);

    p_range_r8: assert property (@(posedge clk) disable iff (rst)
        line_start |=> src_idx <= src_last);

    p_residue_r4: assert property (@(posedge clk) disable iff (rst)
        (step && !line_start && $stable(dst_last) && (acc <= {1'b0, dst_last}))
            |=> acc <= {1'b0, dst_last});

    p_adv_r9: assert property (@(posedge clk) disable iff (rst)
        src_adv |-> (src_idx == $past(src_idx) + W'(1)));

    p_adv_cause_r9: assert property (@(posedge clk) disable iff (rst)
        !step |=> !src_adv);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!step && !line_start) |=> $stable(src_idx) && $stable(acc));
endmodule

bind scale_stepper scale_stepper_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_last  (src_last),
    .dst_last  (dst_last),
    .line_start(line_start),
    .step      (step),
    .src_idx   (src_idx),
    .src_adv   (src_adv),
    .phase     (phase),
    .acc       (acc_q)
);

// File: tb/scale_stepper_bench.sv
module scale_stepper_bench;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] src_last = '0;
    logic [W-1:0] dst_last = '0;
    logic         line_start = 1'b0;
    logic         step = 1'b0;
    logic [W-1:0] src_idx;
    logic         src_adv;
    logic [3:0]   phase;

    int checks = 0;
    int errors = 0;
    longint k = 0;
    int prev_idx = 0;

    always #10 clk = ~clk;

    scale_stepper #(.W(W)) u_scale_stepper (
        .clk(clk), .rst(rst), .src_last(src_last), .dst_last(dst_last),
        .line_start(line_start), .step(step),
        .src_idx(src_idx), .src_adv(src_adv), .phase(phase)
    );

    function automatic int exp_idx(longint kk, int ns, int nd);
        longint v = (kk * ns) / nd;
        return (v > ns - 1) ? ns - 1 : int'(v);
    endfunction

    function automatic int exp_phase(longint kk, int ns, int nd);
        longint r = (kk * ns) % nd;
        return int'((r * 16) / nd);
    endfunction

    task automatic check(string req, int act, int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d (k=%0d)", req, act, expv, k);
        end
    endtask

    // sizes given as counts; bench converts to last-pixel indices (R3)
    task automatic start_line(int ns, int nd);
        @(negedge clk);
        src_last   = W'(ns - 1);
        dst_last   = W'(nd - 1);
        line_start = 1'b1;
        step       = 1'b1;       // R2: clear must win
        @(negedge clk);
        line_start = 1'b0;
        step       = 1'b0;
        k = 0;
        check("R2 idx", int'(src_idx), 0);
        check("R2 phase", int'(phase), 0);
        prev_idx = 0;
    endtask

    task automatic do_step(int ns, int nd, string req);
        int e;
        step = 1'b1;
        @(negedge clk);
        step = 1'b0;
        k++;
        e = exp_idx(k, ns, nd);
        check({req, " R4 idx"}, int'(src_idx), e);
        check("R7 phase", int'(phase), exp_phase(k, ns, nd));
        check("R9 adv", int'(src_adv), (e != prev_idx) ? 1 : 0);
        prev_idx = e;
    endtask

    task automatic idle_check();
        int hold_idx = int'(src_idx);
        int hold_ph  = int'(phase);
        @(negedge clk);
        check("R10 idx", int'(src_idx), hold_idx);
        check("R10 phase", int'(phase), hold_ph);
        check("R9 adv idle", int'(src_adv), 0);
    endtask

    task automatic run_line(int ns, int nd, int extra, bit gaps);
        start_line(ns, nd);
        for (int s = 0; s < nd - 1 + extra; s++) begin
            do_step(ns, nd, "line");
            if (gaps && ($urandom % 4 == 0)) idle_check();
            if (k == nd - 1) check("R6 last", int'(src_idx), ns - 1);
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 idx", int'(src_idx), 0);
        check("R1 phase", int'(phase), 0);
        check("R1 adv", int'(src_adv), 0);

        // R5: 320 -> 1920, one advance per six steps
        start_line(320, 1920);
        for (int s = 1; s <= 12; s++) begin
            do_step(320, 1920, "R5");
            if (s == 6)  check("R5 six", int'(src_idx), 1);
            if (s == 12) check("R5 twelve", int'(src_idx), 2);
        end
        idle_check();
        run_line(320, 1920, 0, 1'b0);

        // equal sizes, single pixel, and R8 saturation past the end
        run_line(7, 7, 0, 1'b0);
        run_line(1, 5, 3, 1'b0);
        run_line(3, 10, 6, 1'b1);
        check("R8 sat", int'(src_idx), 2);
        run_line(256, 1920, 0, 1'b0);

        for (int t = 0; t < 12; t++) begin
            int nd = 1 + int'($urandom % 600);
            int ns = 1 + int'($urandom % nd);
            run_line(ns, nd, int'($urandom % 3), 1'b1);
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule